// File: doc/BRIEF.md
# Sound Memory Host Transfer Port

This block is the host side of a 16-bit-wide sound sample memory. A host loads a transfer pointer through a register write, then either pushes halfwords one at a time through a data port or streams 32-bit beats in or out over a valid/ready burst channel. Each beat carries two consecutive halfwords. The pointer advances after every access and wraps at the end of the memory, and the host can read it back.

The same block watches the block fetches made by playback voices. When an enabled interrupt address falls inside the eight-halfword window of a fetch, it raises a sticky interrupt carrying a fixed code. The memory sits inside the block as two synchronous banks, one for even and one for odd halfword addresses. Its size is a parameter; the default is 1024 halfwords, and 18 address bits give the full 256K×16 arrangement.

Top module: `sound_mem_port`

## Requirements
- R1: A register write to select 0 (address register) with lane 1 set loads the transfer pointer with `reg_wdata[31:16]` × 4, wrapped modulo the memory depth. With lane 0 set, it loads the interrupt address from `reg_wdata[15:0]`. Readback with `rd_sel`=0 returns {pointer / 4, interrupt address}.
- R2: A register write to select 1 with lane 0 set stores `reg_wdata[15:0]` at the pointer and then increments the pointer, wrapping at the memory depth. With lane 1 set, the same write loads the control halfword from `reg_wdata[31:16]`. Readback with `rd_sel`=1 returns {control, last data word}.
- R3: An accepted burst write beat (`bw_valid` and `bw_ready` both high) stores bits 15:0 at halfword n and bits 31:16 at halfword n+1, with wraparound. The pointer then advances by 2.
- R4: While `rd_dir` is high, the block presents beats on `br_data` packed as {halfword n+1, halfword n}. The first beat is valid one cycle after `rd_dir` rises. A beat holds until `br_ready` is high, at most one beat is taken per cycle, and the pointer advances by 2 for each beat fetched.
- R5: A register write to select 2 stores the status word through the mask 0xF800FFFF (lane 0 covers bits 15:0, lane 1 covers bits 31:16). Readback with `rd_sel`=2 returns the stored value.
- R6: When control bit 6 is set, a voice fetch (`fetch_valid`) at block address b sets `irq` on the next cycle if interrupt address × 4 lies in [b, b+7]. While `irq` is high, `irq_code` reads 0x0200; otherwise it reads 0.
- R7: `irq` stays high until a control write with bit 6 low clears it. While control bit 6 is clear, matching fetches are ignored.
- R8: In a cycle that loads the pointer or writes the data port, `bw_ready` is low and no burst read beat is fetched. `bw_ready` is also low while `rd_dir` is high.
- R9: After reset, the pointer, interrupt address, control, data and status registers are 0, and `irq`, `irq_code` and `br_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 data/control, 2 status |
| reg_be | input | 2 | Halfword lanes: bit 0 low half, bit 1 high half |
| reg_wdata | input | 32 | Register write data |
| rd_sel | input | 2 | Readback select |
| rd_data | output | 32 | Readback value |
| bw_valid | input | 1 | Burst write beat valid |
| bw_ready | output | 1 | Burst write beat accepted |
| bw_data | input | 32 | Burst write beat, low half first |
| rd_dir | input | 1 | Burst direction: 1 streams out of memory |
| br_valid | output | 1 | Burst read beat valid |
| br_ready | input | 1 | Burst read beat taken |
| br_data | output | 32 | Burst read beat, low half first |
| fetch_valid | input | 1 | Voice block fetch strobe |
| fetch_addr | input | AW | Voice block halfword address |
| irq | output | 1 | Sticky interrupt |
| irq_code | output | 16 | Interrupt code, 0x0200 when raised |

## Verification
The assertions assume the host keeps `reg_wdata` and the lane bits stable within a strobe cycle. They also assume it changes `rd_dir` only when no read beat would be lost, that is, it lowers it only together with taking the last wanted beat. The bench drives every input just after a rising edge and one handshake at a time. It drops `rd_dir` only in the cycle that takes the final beat, so each pointer and data expectation follows from the count of accepted beats alone. Random addresses, beat counts and idle gaps stay within these rules. Directed cases cover the wrap point, odd pointers, and a pointer load that collides with a waiting beat.

// File: rtl/smp_pkg.sv
package smp_pkg;
  localparam logic [31:0] STATUS_KEEP = 32'hF800_FFFF;
  localparam int          IRQ_EN_BIT  = 6;
  localparam logic [15:0] IRQ_CODE    = 16'h0200;
  localparam int          WIN_SPAN    = 7;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_STAT = 2'd2
  } reg_sel_e;

  function automatic logic [31:0] status_filter(input logic [31:0] v);
    return v & STATUS_KEEP;
  endfunction

  // interrupt halfword address scaled by 4 against an 8-halfword fetch window
  function automatic logic window_hit(input logic [15:0] irq_a, input logic [31:0] blk);
    logic [31:0] t;
    t = {14'b0, irq_a, 2'b00};
    return (t >= blk) && (t <= blk + WIN_SPAN);
  endfunction
endpackage

// File: rtl/smp_ptr.sv
module smp_ptr #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [15:0]   load_val,
  input  logic          step1,
  input  logic          step2,
  output logic [AW-1:0] ptr
);
  localparam int LW = 18;
  logic [LW-1:0] scaled;
  assign scaled = {load_val, 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n)     ptr <= '0;
    else if (load)  ptr <= AW'(scaled);
    else if (step1) ptr <= ptr + AW'(1);
    else if (step2) ptr <= ptr + AW'(2);
  end
endmodule

// File: rtl/smp_bank.sv
module smp_bank #(
  parameter int BW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [BW-1:0] idx,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata
);
  localparam int N = 1 << BW;
  logic [15:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) rdata <= mem[idx];
  end
endmodule

// File: rtl/smp_irq.sv
module smp_irq #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic [15:0]   irq_addr,
  input  logic          clr,
  output logic          hit,
  output logic          irq
);
  import smp_pkg::*;
  assign hit = en && fetch_valid && window_hit(irq_addr, 32'(fetch_addr));

  always_ff @(posedge clk) begin
    if (!rst_n)   irq <= 1'b0;
    else if (clr) irq <= 1'b0;
    else if (hit) irq <= 1'b1;
  end
endmodule

// File: rtl/sound_mem_port.sv
module sound_mem_port #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [1:0]    reg_be,
  input  logic [31:0]   reg_wdata,
  input  logic [1:0]    rd_sel,
  output logic [31:0]   rd_data,
  input  logic          bw_valid,
  output logic          bw_ready,
  input  logic [31:0]   bw_data,
  input  logic          rd_dir,
  output logic          br_valid,
  input  logic          br_ready,
  output logic [31:0]   br_data,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  output logic          irq,
  output logic [15:0]   irq_code
);
  import smp_pkg::*;
  localparam int BW = AW - 1;

  logic [AW-1:0] ptr, ptr_p1;
  logic [15:0]   irq_addr, ctrl, last_data;
  logic [31:0]   status_q, status_nxt;
  logic          ptr_load, data_we, ptr_touch, beat_we, rd_issue;
  logic          slot_valid, slot_swap, irq_clr, irq_hit;
  logic [15:0]   bank_q [2];

  assign ptr_p1    = ptr + AW'(1);
  assign ptr_load  = reg_wr && (reg_sel == SEL_ADDR) && reg_be[1];
  assign data_we   = reg_wr && (reg_sel == SEL_DATA) && reg_be[0];
  assign ptr_touch = ptr_load || data_we;
  assign bw_ready  = !rd_dir && !ptr_touch;
  assign beat_we   = bw_valid && bw_ready;
  assign rd_issue  = rd_dir && !ptr_touch && (!slot_valid || br_ready);
  assign irq_clr   = reg_wr && (reg_sel == SEL_DATA) && reg_be[1] && !reg_wdata[16 + IRQ_EN_BIT];

  smp_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(reg_wdata[31:16]),
    .step1(data_we), .step2(beat_we || rd_issue), .ptr(ptr)
  );

  // bank g holds halfwords whose address LSB equals g
  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic          own;
    logic [BW-1:0] idx;
    logic [15:0]   wd;
    assign own = (ptr[0] == 1'(g));
    assign idx = own ? ptr[AW-1:1] : ptr_p1[AW-1:1];
    assign wd  = data_we ? reg_wdata[15:0] : (own ? bw_data[15:0] : bw_data[31:16]);
    smp_bank #(.BW(BW)) u_bank (
      .clk(clk), .we((data_we && own) || beat_we), .re(rd_issue),
      .idx(idx), .wdata(wd), .rdata(bank_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_valid <= 1'b0;
      slot_swap  <= 1'b0;
    end else begin
      if (rd_issue) begin
        slot_valid <= 1'b1;
        slot_swap  <= ptr[0];
      end else if (ptr_load || br_ready) begin
        slot_valid <= 1'b0;
      end
    end
  end

  assign br_valid = slot_valid;
  assign br_data  = slot_swap ? {bank_q[0], bank_q[1]} : {bank_q[1], bank_q[0]};

  always_comb begin
    status_nxt[31:16] = reg_be[1] ? reg_wdata[31:16] : status_q[31:16];
    status_nxt[15:0]  = reg_be[0] ? reg_wdata[15:0]  : status_q[15:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_addr  <= '0;
      ctrl      <= '0;
      last_data <= '0;
      status_q  <= '0;
    end else if (reg_wr) begin
      if (reg_sel == SEL_ADDR && reg_be[0]) irq_addr  <= reg_wdata[15:0];
      if (reg_sel == SEL_DATA && reg_be[1]) ctrl      <= reg_wdata[31:16];
      if (data_we)                          last_data <= reg_wdata[15:0];
      if (reg_sel == SEL_STAT)              status_q  <= status_filter(status_nxt);
    end
  end

  smp_irq #(.AW(AW)) u_irq (
    .clk(clk), .rst_n(rst_n), .en(ctrl[IRQ_EN_BIT]), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .irq_addr(irq_addr), .clr(irq_clr),
    .hit(irq_hit), .irq(irq)
  );
  assign irq_code = irq ? IRQ_CODE : 16'h0000;

  always_comb begin
    case (rd_sel)
      SEL_ADDR: rd_data = {16'(ptr >> 2), irq_addr};
      SEL_DATA: rd_data = {ctrl, last_data};
      SEL_STAT: rd_data = status_q;
      default:  rd_data = 32'h0;
    endcase
  end
endmodule

// File: rtl/smp_chk.sv
module smp_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ptr_load,
  input logic [15:0]   load_val,
  input logic          data_we,
  input logic          beat_we,
  input logic          rd_issue,
  input logic [AW-1:0] ptr,
  input logic [31:0]   status_q,
  input logic          irq,
  input logic          irq_clr,
  input logic          irq_hit,
  input logic          bw_ready,
  input logic          rd_dir,
  input logic          br_valid,
  input logic          br_ready
);
  import smp_pkg::*;

  assert_addr_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> ptr == AW'({$past(load_val), 2'b00}));

  assert_data_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |=> ptr == AW'($past(ptr) + AW'(1)));

  assert_beat_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_we |=> ptr == AW'($past(ptr) + AW'(2)));

  assert_read_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !br_ready && !ptr_load) |=> br_valid);

  assert_status_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & ~STATUS_KEEP) == 32'h0);

  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !irq_hit) |=> !irq);

  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_load || data_we || rd_dir) |-> !bw_ready);

  assert_one_mover_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ptr_load, data_we, beat_we, rd_issue}) <= 1);
endmodule

bind sound_mem_port smp_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .load_val(reg_wdata[31:16]),
  .data_we(data_we), .beat_we(beat_we), .rd_issue(rd_issue), .ptr(ptr),
  .status_q(status_q), .irq(irq), .irq_clr(irq_clr), .irq_hit(irq_hit),
  .bw_ready(bw_ready), .rd_dir(rd_dir), .br_valid(br_valid), .br_ready(br_ready)
);

// File: tb/sound_mem_port_test.sv
`timescale 1ns/1ps
module sound_mem_port_test;
  localparam int AW = 10;
  localparam int D  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_sel = '0, reg_be = '0, rd_sel = '0;
  logic [31:0]   reg_wdata = '0, bw_data = '0;
  logic [31:0]   rd_data, br_data;
  logic          bw_valid = 1'b0, rd_dir = 1'b0, br_ready = 1'b0, fetch_valid = 1'b0;
  logic          bw_ready, br_valid, irq;
  logic [AW-1:0] fetch_addr = '0;
  logic [15:0]   irq_code;

  int errors = 0, checks = 0;
  logic [15:0] m [D];
  int p = 0;
  logic [15:0] irqa = 0;

  always #2.5 clk = ~clk;

  sound_mem_port #(.AW(AW)) uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic int scale_addr(input logic [15:0] v);
    return (int'(v) * 4) % D;
  endfunction

  function automatic logic [31:0] addr_view();
    return {16'(p / 4), irqa};
  endfunction

  task automatic reg_write(input logic [1:0] sel, input logic [1:0] be, input logic [31:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_be = be; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_be = '0;
    if (sel == 2'd0 && be[1]) p = scale_addr(d[31:16]);
    if (sel == 2'd0 && be[0]) irqa = d[15:0];
    if (sel == 2'd1 && be[0]) begin m[p] = d[15:0]; p = (p + 1) % D; end
  endtask

  task automatic burst_write(input int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] d;
      d = $urandom;
      bw_valid = 1'b1; bw_data = d;
      forever begin
        @(negedge clk);
        if (bw_ready) break;
        step();
      end
      step();
      bw_valid = 1'b0;
      m[p] = d[15:0]; m[(p + 1) % D] = d[31:16]; p = (p + 2) % D;
      if ($urandom % 3 == 0) step();
    end
  endtask

  task automatic burst_read(input int n);
    rd_dir = 1'b1; br_ready = 1'b0;
    step();
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R4 beat valid", 32'(br_valid), 32'd1);
      chk("R4 beat data", br_data, {m[(p + 1) % D], m[p]});
      p = (p + 2) % D;
      if (i == n - 1) rd_dir = 1'b0;
      br_ready = 1'b1;
      step();
      br_ready = 1'b0;
      if ($urandom % 2 == 0) step();
    end
  endtask

  task automatic fetch(input int a);
    fetch_valid = 1'b1; fetch_addr = AW'(a);
    step();
    fetch_valid = 1'b0;
  endtask

  initial begin
    #(1_000_000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R9 reset state
    @(negedge clk);
    rd_sel = 2'd0; #0.1 chk("R9 addr reg", rd_data, 32'h0);
    rd_sel = 2'd1; #0.1 chk("R9 data/ctrl", rd_data, 32'h0);
    rd_sel = 2'd2; #0.1 chk("R9 status", rd_data, 32'h0);
    chk("R9 irq", {irq_code, 15'b0, irq}, 32'h0);
    chk("R9 br_valid", 32'(br_valid), 32'd0);
    step();

    // R1 address load with wrap
    reg_write(2'd0, 2'b11, {16'h0123, 16'h00AA});
    @(negedge clk); rd_sel = 2'd0; #0.1
    chk("R1 load wrap", rd_data, {16'h0023, 16'h00AA});
    chk("R1 model", rd_data, addr_view());
    step();

    // R2 data port across the wrap point
    reg_write(2'd0, 2'b10, {16'(255), 16'h0});
    for (int i = 0; i < 6; i++) reg_write(2'd1, 2'b01, {16'h0, 16'(16'hA000 + i)});
    @(negedge clk); rd_sel = 2'd0; #0.1
    chk("R2 pointer wrap", rd_data, addr_view());
    rd_sel = 2'd1; #0.1
    chk("R2 last data", rd_data, {16'h0, 16'hA005});
    step();
    reg_write(2'd0, 2'b10, {16'(255), 16'h0});
    burst_read(3);

    // R3 / R4 random bursts
    for (int r = 0; r < 24; r++) begin
      int n;
      logic [15:0] av;
      av = 16'($urandom % 256);
      n = 1 + int'($urandom % 8);
      reg_write(2'd0, 2'b10, {av, 16'h0});
      if (r % 3 == 1) reg_write(2'd1, 2'b01, {16'h0, 16'($urandom)});
      begin
        int start;
        start = p;
        burst_write(n);
        @(negedge clk); rd_sel = 2'd0; #0.1
        chk("R3 pointer after beats", rd_data, addr_view());
        step();
        reg_write(2'd0, 2'b10, {av, 16'h0});
        if (r % 3 == 1) begin
          reg_write(2'd1, 2'b01, {16'h0, m[p]});
        end
        if (p != start) chk("R3 start", 32'(p), 32'(start));
        burst_read(n);
        @(negedge clk); rd_sel = 2'd0; #0.1
        chk("R4 pointer after read", rd_data, addr_view());
        step();
      end
    end

    // R8 pointer load collides with a waiting beat
    bw_valid = 1'b1; bw_data = 32'hDEAD_BEEF;
    reg_wr = 1'b1; reg_sel = 2'd0; reg_be = 2'b10; reg_wdata = {16'h0010, 16'h0};
    @(negedge clk);
    chk("R8 ready low on load", 32'(bw_ready), 32'd0);
    step();
    reg_wr = 1'b0; reg_be = '0; bw_valid = 1'b0; p = scale_addr(16'h0010);
    @(negedge clk); rd_sel = 2'd0; #0.1
    chk("R8 pointer not stepped", rd_data, addr_view());
    rd_dir = 1'b1; #0.1
    chk("R8 ready low in read dir", 32'(bw_ready), 32'd0);
    rd_dir = 1'b0;
    step();

    // R5 status mask
    reg_write(2'd2, 2'b11, 32'hFFFF_FFFF);
    @(negedge clk); rd_sel = 2'd2; #0.1
    chk("R5 mask all ones", rd_data, 32'hF800_FFFF);
    step();
    reg_write(2'd2, 2'b10, 32'h1234_0000);
    @(negedge clk); #0.1
    chk("R5 upper lane only", rd_data, 32'h1000_FFFF);
    step();

    // R6 / R7 interrupt window
    reg_write(2'd0, 2'b01, {16'h0, 16'h0020});
    fetch(16'h80);
    @(negedge clk);
    chk("R7 ignored while disabled", {irq_code, 15'b0, irq}, 32'h0);
    step();
    reg_write(2'd1, 2'b10, {16'h0040, 16'h0});
    fetch(16'h78);
    @(negedge clk);
    chk("R6 miss below window", 32'(irq), 32'd0);
    step();
    fetch(16'h81);
    @(negedge clk);
    chk("R6 miss above window", 32'(irq), 32'd0);
    step();
    fetch(16'h79);
    @(negedge clk);
    chk("R6 hit at window top", {irq_code, 15'b0, irq}, {16'h0200, 16'h0001});
    step();
    repeat (3) step();
    @(negedge clk);
    chk("R7 sticky", 32'(irq), 32'd1);
    step();
    reg_write(2'd1, 2'b10, {16'h0000, 16'h0});
    @(negedge clk);
    chk("R7 cleared", {irq_code, 15'b0, irq}, 32'h0);
    step();
    reg_write(2'd1, 2'b10, {16'h0040, 16'h0});
    fetch(16'h80);
    @(negedge clk);
    chk("R6 hit at window base", 32'(irq), 32'd1);
    step();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule